// File: doc/BRIEF.md
# Flash Buffered-Program Command Sequencer

This block is the command front end of a NOR-style flash memory model. It watches bus write cycles and recognises two programming sequences. Each begins with two unlock writes and a setup write: a normal buffered program that takes a word count and then loads words within one page, and an enhanced buffered program that takes one full, strictly ascending run of words sharing the same upper address bits. Loaded words are held in an internal buffer and go to the memory array only when a confirm write arrives. Any illegal cycle during loading or in the confirm slot aborts the operation.

After a confirm, the block stays busy for a fixed number of clock cycles that models the programming time. At the end of that time it merges the buffer into the array. While the block is busy, or after an abort or a program fail, a read returns a status byte instead of array data. A reset command returns the block from the abort or fail condition to idle. The memory array starts blank (all zeros), and programming ORs the new data into the stored word.

Top module: `flash_bufprog_seq`

## Requirements
- R1: A command starts only with 0xAA written to word address 0x555, then 0x55 written to 0x2AA (compared on address bits 10:0, data bits 7:0). Any other write in either unlock slot, or a third write that is neither 0x25 nor 0x33, returns the block silently to idle. Reads then return array data.
- R2: After setup 0x25 (normal mode), the next write carries the word count minus one. A value of PAGE_W (2**PAGE_LOG2) or more aborts the operation.
- R3: In normal mode, each load counts down the announced number of loads. When one address is loaded more than once, the last value loaded is programmed, and other loaded words keep their own values.
- R4: In normal mode, a load whose page (address bits AW-1:PAGE_LOG2) differs from that of the first load aborts the operation.
- R5: After setup 0x33 (enhanced mode), exactly ENH_W (2**ENH_LOG2) loads must follow, with low address bits ENH_LOG2-1:0 running 0, 1, ... ENH_W-1. A skipped or out-of-order index aborts the operation. A complete run programs every word.
- R6: In enhanced mode, a load whose upper address bits (AW-1:ENH_LOG2) differ from those of the first load aborts the operation.
- R7: Nothing is programmed until a confirm write (data 0x29) arrives in the slot after the last load. Any other data in that slot aborts the operation and leaves the array unchanged.
- R8: After a confirm, the block is busy for PROG_CYC cycles. The busy time is 2*PROG_CYC when a normal-mode first load address is not aligned to a page boundary. A read captured in the last busy cycle returns status, and the next read returns the programmed data.
- R9: The status byte sits in the low byte of the read data. Bit 7 is the inverse of bit 7 of the last loaded word. Bit 6 flips on every status read. Bit 5 flags a program fail. Bit 1 flags an abort. All other bits are zero.
- R10: An abort sets status bit 1, and every read returns status until a write with data 0xF0. After that, the block is idle and reads return array data.
- R11: Programming stores the OR of the old word and the new word. If a word that is already nonzero receives a bit it lacks, status bit 5 sets after the busy time and holds until a 0xF0 write.
- R12: Bus writes made while the block is busy, including 0xF0, are ignored and do not shorten the busy time.
- R13: After reset, the block is idle and every array word reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one cycle per bus write |
| bus_re | input | 1 | Read strobe, one cycle per bus read |
| bus_addr | input | AW | Word address for reads and writes |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data: array word or status byte |

## Verification
The bench builds the block with the default address width of 11 bits, a 256-word enhanced buffer and 32-word pages, and shortens the programming time to 12 cycles. With 256 loads, the full enhanced run, including the last-index and confirm boundaries, fits easily in a short run. The short program time lets the bench place reads exactly in the last busy cycle and in the first idle cycle, for both the single and the doubled time. The 32-word page lets a count of 32 and a load one page over act as the rejection cases.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_UNL1, ST_UNL2, ST_NCNT, ST_NLOAD,
    ST_NCONF, ST_ELOAD, ST_ECONF, ST_BUSY, ST_HALT
  } fbp_state_e;

  localparam logic [10:0] KEY_ADDR_A = 11'h555;
  localparam logic [10:0] KEY_ADDR_B = 11'h2AA;
  localparam logic [7:0]  KEY_DATA_A = 8'hAA;
  localparam logic [7:0]  KEY_DATA_B = 8'h55;
  localparam logic [7:0]  OP_NORMAL  = 8'h25;
  localparam logic [7:0]  OP_ENHANCE = 8'h33;
  localparam logic [7:0]  OP_COMMIT  = 8'h29;
  localparam logic [7:0]  OP_RESET   = 8'hF0;

  // busy length for one operation
  function automatic int unsigned prog_cycles(input bit enh, input bit aligned,
                                              input int unsigned base);
    return (enh || aligned) ? base : 2 * base;
  endfunction

  // two addresses fall in the same region above bit lsb
  function automatic bit same_region(input logic [31:0] a, input logic [31:0] b,
                                     input int unsigned lsb);
    return (a >> lsb) == (b >> lsb);
  endfunction

  function automatic logic [7:0] status_byte(input logic d7_inv, input logic tog,
                                             input logic fail, input logic abrt);
    return {d7_inv, tog, fail, 3'b000, abrt, 1'b0};
  endfunction

endpackage

// File: rtl/fbp_buffer.sv
module fbp_buffer #(
  parameter int DW       = 16,
  parameter int ENH_LOG2 = 8,
  localparam int ENH_W   = 1 << ENH_LOG2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                ld_en,
  input  logic [ENH_LOG2-1:0] ld_idx,
  input  logic [DW-1:0]       ld_data,
  output logic [DW-1:0]       buf_data [ENH_W],
  output logic [ENH_W-1:0]    buf_vld
);

  for (genvar i = 0; i < ENH_W; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (ld_en && ld_idx == ENH_LOG2'(i)) buf_data[i] <= ld_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               buf_vld[i] <= 1'b0;
      else if (clr)                             buf_vld[i] <= 1'b0;
      else if (ld_en && ld_idx == ENH_LOG2'(i)) buf_vld[i] <= 1'b1;
    end
  end

  // R3: a fresh setup leaves no stale word behind
  p_clear_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (buf_vld == '0));

endmodule

// File: rtl/fbp_array.sv
module fbp_array #(
  parameter int AW       = 11,
  parameter int DW       = 16,
  parameter int ENH_LOG2 = 8,
  localparam int ENH_W   = 1 << ENH_LOG2,
  localparam int HW      = AW - ENH_LOG2,
  localparam int DEPTH   = 1 << AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [HW-1:0]    base_hi,
  input  logic [DW-1:0]    buf_data [ENH_W],
  input  logic [ENH_W-1:0] buf_vld,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_word,
  output logic             fail_det
);

  logic [DW-1:0] mem [DEPTH];

  assign rd_word = mem[rd_addr];

  always_comb begin
    fail_det = 1'b0;
    for (int i = 0; i < ENH_W; i++) begin
      logic [DW-1:0] old_w;
      old_w = mem[{base_hi, ENH_LOG2'(i)}];
      if (buf_vld[i] && old_w != '0 && ((old_w | buf_data[i]) != old_w))
        fail_det = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
    end else if (commit) begin
      for (int i = 0; i < ENH_W; i++)
        if (buf_vld[i])
          mem[{base_hi, ENH_LOG2'(i)}] <= mem[{base_hi, ENH_LOG2'(i)}] | buf_data[i];
    end
  end

  // R11: a commit never clears a bit of the word being read
  p_or_keeps_bits_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && $stable(rd_addr)) |=> ((rd_word & $past(rd_word)) == $past(rd_word)));

endmodule

// File: rtl/fbp_ctrl.sv
module fbp_ctrl
  import fbp_pkg::*;
#(
  parameter int AW        = 11,
  parameter int DW        = 16,
  parameter int ENH_LOG2  = 8,
  parameter int PAGE_LOG2 = 5,
  parameter int PROG_CYC  = 12,
  localparam int ENH_W    = 1 << ENH_LOG2,
  localparam int PAGE_W   = 1 << PAGE_LOG2,
  localparam int CW       = $clog2(2 * PROG_CYC + 1),
  localparam int RW       = PAGE_LOG2 + 1,
  localparam int HW       = AW - ENH_LOG2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic                re,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       wdata,
  input  logic                fail_det,
  output logic                ld_en,
  output logic [ENH_LOG2-1:0] ld_idx,
  output logic                clr,
  output logic                commit,
  output logic [HW-1:0]       base_hi,
  output logic                show_status,
  output logic [7:0]          stat
);

  fbp_state_e          state;
  logic                first_q, enh_q, d7_q, fail_q, abort_q, tog_q;
  logic [AW-1:0]       base_q;
  logic [RW-1:0]       remain_q;
  logic [ENH_LOG2-1:0] idx_q;
  logic [CW-1:0]       cnt_q;

  logic [7:0]  cmd;
  logic [10:0] a11;
  assign cmd = wdata[7:0];
  assign a11 = addr[10:0];

  // named events
  logic same_pg, same_hi, n_load, e_load, n_ok, e_ok, in_conf, conf_ok, cnt_bad, seq_err;
  assign same_pg = first_q || same_region(32'(addr), 32'(base_q), PAGE_LOG2);
  assign same_hi = first_q || same_region(32'(addr), 32'(base_q), ENH_LOG2);
  assign n_load  = we && state == ST_NLOAD;
  assign e_load  = we && state == ST_ELOAD;
  assign n_ok    = n_load && same_pg;
  assign e_ok    = e_load && same_hi && addr[ENH_LOG2-1:0] == idx_q;
  assign in_conf = state == ST_NCONF || state == ST_ECONF;
  assign conf_ok = we && in_conf && cmd == OP_COMMIT;
  assign cnt_bad = we && state == ST_NCNT && 32'(wdata) >= PAGE_W;
  assign seq_err = (n_load && !same_pg) || (e_load && !e_ok) ||
                   (we && in_conf && cmd != OP_COMMIT) || cnt_bad;

  assign ld_en       = n_ok || e_ok;
  assign ld_idx      = addr[ENH_LOG2-1:0];
  assign clr         = we && state == ST_UNL2 && (cmd == OP_NORMAL || cmd == OP_ENHANCE);
  assign commit      = state == ST_BUSY && cnt_q == CW'(1);
  assign base_hi     = base_q[AW-1:ENH_LOG2];
  assign show_status = state == ST_BUSY || state == ST_HALT;
  assign stat        = status_byte(~d7_q, tog_q, fail_q, abort_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; first_q <= 1'b1; enh_q <= 1'b0; d7_q <= 1'b0;
      fail_q <= 1'b0; abort_q <= 1'b0; tog_q <= 1'b0; base_q <= '0;
      remain_q <= '0; idx_q <= '0; cnt_q <= '0;
    end else begin
      if (re && show_status) tog_q <= ~tog_q;
      if (ld_en) begin
        d7_q    <= wdata[7];
        first_q <= 1'b0;
        if (first_q) base_q <= addr;
      end
      if (seq_err) begin
        abort_q <= 1'b1;
        state   <= ST_HALT;
      end else begin
        case (state)
          ST_IDLE:  if (we && a11 == KEY_ADDR_A && cmd == KEY_DATA_A) state <= ST_UNL1;
          ST_UNL1:  if (we) state <= (a11 == KEY_ADDR_B && cmd == KEY_DATA_B) ? ST_UNL2 : ST_IDLE;
          ST_UNL2:  if (we) begin
                      first_q <= 1'b1;
                      idx_q   <= '0;
                      enh_q   <= cmd == OP_ENHANCE;
                      state   <= cmd == OP_NORMAL  ? ST_NCNT :
                                 cmd == OP_ENHANCE ? ST_ELOAD : ST_IDLE;
                    end
          ST_NCNT:  if (we) begin
                      remain_q <= RW'(wdata[PAGE_LOG2-1:0]) + RW'(1);
                      state    <= ST_NLOAD;
                    end
          ST_NLOAD: if (n_ok) begin
                      remain_q <= remain_q - RW'(1);
                      if (remain_q == RW'(1)) state <= ST_NCONF;
                    end
          ST_ELOAD: if (e_ok) begin
                      idx_q <= idx_q + ENH_LOG2'(1);
                      if (idx_q == ENH_LOG2'(ENH_W - 1)) state <= ST_ECONF;
                    end
          ST_NCONF, ST_ECONF: if (conf_ok) begin
                      cnt_q <= CW'(prog_cycles(enh_q, base_q[PAGE_LOG2-1:0] == '0, PROG_CYC));
                      state <= ST_BUSY;
                    end
          ST_BUSY:  if (commit) begin
                      fail_q <= fail_det;
                      state  <= fail_det ? ST_HALT : ST_IDLE;
                    end else cnt_q <= cnt_q - CW'(1);
          ST_HALT:  if (we && cmd == OP_RESET) begin
                      abort_q <= 1'b0;
                      fail_q  <= 1'b0;
                      state   <= ST_IDLE;
                    end
          default:  state <= ST_IDLE;
        endcase
      end
    end
  end

  // R7: busy is entered only from a confirm write
  p_busy_needs_confirm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == ST_BUSY) |-> $past(we && cmd == OP_COMMIT));
  // R12: busy holds until its count runs out, whatever is written
  p_busy_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUSY && cnt_q > CW'(1)) |=> state == ST_BUSY);
  // R5: the confirm slot of the enhanced run follows the last index only
  p_enh_full_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ECONF && $past(state) == ST_ELOAD) |-> $past(idx_q) == ENH_LOG2'(ENH_W - 1));
  // R3: the load state always has loads left to take
  p_loads_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_NLOAD |-> remain_q != '0);
  // R10: halt is reached only through an abort or an end of busy
  p_halt_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT && $past(state) != ST_HALT) |-> $past(seq_err || commit));
  // R10: idle never carries an abort flag
  p_idle_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_IDLE |-> !abort_q);

endmodule

// File: rtl/flash_bufprog_seq.sv
module flash_bufprog_seq #(
  parameter int AW        = 11,
  parameter int DW        = 16,
  parameter int ENH_LOG2  = 8,
  parameter int PAGE_LOG2 = 5,
  parameter int PROG_CYC  = 12,
  localparam int ENH_W    = 1 << ENH_LOG2,
  localparam int HW       = AW - ENH_LOG2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata
);

  logic                ld_en, clr, commit, show_status, fail_det;
  logic [ENH_LOG2-1:0] ld_idx;
  logic [HW-1:0]       base_hi;
  logic [7:0]          stat;
  logic [DW-1:0]       buf_data [ENH_W];
  logic [ENH_W-1:0]    buf_vld;
  logic [DW-1:0]       rd_word;

  fbp_ctrl #(.AW(AW), .DW(DW), .ENH_LOG2(ENH_LOG2), .PAGE_LOG2(PAGE_LOG2),
             .PROG_CYC(PROG_CYC)) u_ctrl (
    .clk, .rst_n, .we(bus_we), .re(bus_re), .addr(bus_addr), .wdata(bus_wdata),
    .fail_det, .ld_en, .ld_idx, .clr, .commit, .base_hi, .show_status, .stat);

  fbp_buffer #(.DW(DW), .ENH_LOG2(ENH_LOG2)) u_buf (
    .clk, .rst_n, .clr, .ld_en, .ld_idx, .ld_data(bus_wdata), .buf_data, .buf_vld);

  fbp_array #(.AW(AW), .DW(DW), .ENH_LOG2(ENH_LOG2)) u_arr (
    .clk, .rst_n, .commit, .base_hi, .buf_data, .buf_vld, .rd_addr(bus_addr),
    .rd_word, .fail_det);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= show_status ? DW'(stat) : rd_word;
  end

  // R9: status reads keep all unused bits at zero
  p_status_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && show_status) |=> (bus_rdata & ~DW'(8'hE2)) == '0);

endmodule

// File: tb/flash_bufprog_seq_tb.sv
module flash_bufprog_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11, DW = 16, ENH_LOG2 = 8, PAGE_LOG2 = 5, PROG_CYC = 12;
  localparam int ENH_W = 1 << ENH_LOG2;
  localparam logic [15:0] SMASK = 16'h00A2;   // status bits 7,5,1
  localparam logic [15:0] FULL  = 16'hFFFF;

  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0, bus_re = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;

  flash_bufprog_seq #(.AW(AW), .DW(DW), .ENH_LOG2(ENH_LOG2), .PAGE_LOG2(PAGE_LOG2),
                      .PROG_CYC(PROG_CYC)) dut_i (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct { logic [15:0] exp; logic [15:0] mask; string tag; } exp_t;
  exp_t sb_q[$];
  int checks = 0, fails = 0;
  logic pend = 1'b0;
  logic [15:0] last_rd = '0;

  function automatic logic [15:0] enh_word(input int i);
    return 16'((i * 37 + 5) & 16'hFFFF);
  endfunction

  // monitor: pops an expectation for every captured read
  always @(posedge clk) pend <= bus_re;
  always @(negedge clk) begin
    if (pend) begin
      exp_t e;
      checks++;
      if (sb_q.size() == 0) begin
        fails++;
        $display("FAIL scoreboard empty got %h exp none", bus_rdata);
      end else begin
        e = sb_q.pop_front();
        if ((bus_rdata & e.mask) != (e.exp & e.mask)) begin
          fails++;
          $display("FAIL %s got %h exp %h (mask %h)", e.tag, bus_rdata, e.exp, e.mask);
        end
      end
      last_rd = bus_rdata;
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [15:0] e, input logic [15:0] m,
                    input string tag);
    exp_t x;
    x.exp = e; x.mask = m; x.tag = tag;
    sb_q.push_back(x);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    #1;
  endtask

  task automatic unlock();
    wr(11'h555, 16'h00AA);
    wr(11'h2AA, 16'h0055);
  endtask

  task automatic direct(input bit ok, input string tag, input logic [15:0] got,
                        input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog got timeout exp completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] first_stat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13: blank after reset
    rd(11'h000, 16'h0000, FULL, "R13 reset word 0x000");
    rd(11'h7FF, 16'h0000, FULL, "R13 reset word 0x7FF");

    // R3 / R8 aligned: three loads, address 0x080 twice, last wins
    unlock(); wr(0, 16'h0025); wr(0, 16'd2);
    wr(11'h080, 16'h1111); wr(11'h081, 16'h2222); wr(11'h080, 16'h00F5);
    wr(0, 16'h0029);
    repeat (PROG_CYC - 1) @(negedge clk);
    rd(11'h080, 16'h0000, SMASK, "R8 R9 last busy cycle, DQ7 inverse of bit7=1");
    rd(11'h080, 16'h00F5, FULL, "R3 R8 last load wins after PROG_CYC");
    rd(11'h081, 16'h2222, FULL, "R3 other word kept");

    // R1: broken unlock and unknown op leave the block idle
    wr(11'h555, 16'h00AA); wr(11'h2AB, 16'h0055);
    rd(11'h081, 16'h2222, FULL, "R1 bad second unlock returns idle");
    unlock(); wr(0, 16'h0077);
    rd(11'h081, 16'h2222, FULL, "R1 unknown setup returns idle");

    // R8 unaligned + R12 write during busy ignored
    unlock(); wr(0, 16'h0025); wr(0, 16'd0);
    wr(11'h0A3, 16'h0042);
    wr(0, 16'h0029);
    wr(0, 16'h00F0);                       // ignored, busy
    repeat (2 * PROG_CYC - 2) @(negedge clk);
    rd(11'h0A3, 16'h0080, SMASK, "R8 R12 still busy at 2*PROG_CYC");
    rd(11'h0A3, 16'h0042, FULL, "R8 unaligned program done");

    // R2: count too large
    unlock(); wr(0, 16'h0025); wr(0, 16'h0020);
    rd(0, 16'h0002, 16'h0022, "R2 count 32 aborts");
    wr(0, 16'h00F0);
    rd(11'h080, 16'h00F5, FULL, "R10 reset command returns to array reads");

    // R4: second load in the next page
    unlock(); wr(0, 16'h0025); wr(0, 16'd1);
    wr(11'h040, 16'h0101); wr(11'h060, 16'h0202);
    rd(0, 16'h0002, 16'h0022, "R4 page change aborts");
    rd(0, 16'h0002, 16'h0022, "R10 abort held over reads");
    wr(0, 16'h00F0);
    rd(11'h040, 16'h0000, FULL, "R4 aborted load not programmed");

    // R7: wrong confirm
    unlock(); wr(0, 16'h0025); wr(0, 16'd0);
    wr(11'h010, 16'h1234); wr(0, 16'h0030);
    rd(0, 16'h0002, 16'h0022, "R7 wrong confirm aborts");
    wr(0, 16'h00F0);
    rd(11'h010, 16'h0000, FULL, "R7 array unchanged");

    // R5: index skipped
    unlock(); wr(0, 16'h0033);
    wr(11'h400, 16'h0001); wr(11'h402, 16'h0002);
    rd(0, 16'h0002, 16'h0022, "R5 skipped index aborts");
    wr(0, 16'h00F0);
    rd(11'h400, 16'h0000, FULL, "R5 aborted run not programmed");

    // R6: upper bits change
    unlock(); wr(0, 16'h0033);
    wr(11'h400, 16'h0001); wr(11'h501, 16'h0002);
    rd(0, 16'h0002, 16'h0022, "R6 upper address change aborts");
    wr(0, 16'h00F0);

    // R5: full enhanced run at 0x300
    unlock(); wr(0, 16'h0033);
    for (int i = 0; i < ENH_W; i++) wr(AW'(11'h300 | i), enh_word(i));
    wr(0, 16'h0029);
    repeat (PROG_CYC - 1) @(negedge clk);
    rd(0, {8'h00, ~enh_word(ENH_W - 1)[7], 7'h00}, SMASK, "R5 R9 busy at PROG_CYC");
    rd(11'h300, enh_word(0), FULL, "R5 word 0");
    rd(11'h301, enh_word(1), FULL, "R5 word 1");
    rd(11'h380, enh_word(128), FULL, "R5 word 128");
    rd(11'h3FF, enh_word(255), FULL, "R5 word 255");

    // R11: reprogram nonzero word with new bit
    unlock(); wr(0, 16'h0025); wr(0, 16'd0);
    wr(11'h300, 16'h0002); wr(0, 16'h0029);
    repeat (PROG_CYC - 1) @(negedge clk);
    rd(0, 16'h0080, SMASK, "R11 busy, no fail yet");
    first_stat = last_rd;
    rd(0, 16'h00A0, SMASK, "R11 fail flag after program");
    direct(first_stat[6] != last_rd[6], "R9 DQ6 toggles between status reads",
           last_rd, {last_rd[15:7], ~first_stat[6], last_rd[5:0]});
    rd(0, 16'h00A0, SMASK, "R11 fail flag held");
    wr(0, 16'h00F0);
    rd(11'h300, 16'h0007, FULL, "R11 stored value is OR of old and new");

    repeat (2) @(negedge clk);
    direct(sb_q.size() == 0, "scoreboard drained", 16'(sb_q.size()), 16'h0000);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule